// File: doc/BRIEF.md
# Privileged Mode Serialization Sequencer

This block enforces a hard ordering fence around entry to and exit from a privileged firmware mode. When a privileged-call instruction reaches the writeback stage, the sequencer holds fetch and issue and requests a full pipeline flush. It then asks every write buffer to drain, sends a single-cycle pulse that clears the load-linked/store-conditional reservation, and redirects the PC to the privileged base address with PC bit 0 set. It also saves the address of the instruction after the call into an exception-address register.

When a privileged-return instruction is seen in privileged mode, the sequencer holds fetch and flushes the pipeline. It then redirects the PC to the saved exception address with bit 0 cleared, which drops privileged mode, and finally clears the reservation.

Each phase that depends on another unit waits for that unit's done handshake before the sequence moves on. As a result, no instruction from either side of a boundary can survive into the other side.

Top module: `pmode_seq_top`

## Requirements
- R1: While reset is asserted and after it is released, the block is idle: no flush, drain, clear or redirect request is raised, hold_fetch is 0, priv_mode is 0 and exc_addr is 0.
- R2: A privileged-call accepted in normal mode drives act_evt to 2'b01 in the same cycle it is presented. A privileged-return accepted in privileged mode drives act_evt to 2'b10. In all other cycles act_evt is 2'b00. hold_fetch is 1 from the detection cycle through the redirect cycle and returns to 0 once the sequence ends.
- R3: flush_req rises in the cycle after detection and stays high until flush_done is sampled high. No drain request is raised while flush_req is high.
- R4: On entry, every drain_req bit rises in the cycle after flush_done. Each bit falls in the cycle after its own drain_done bit is seen. The sequence continues only once all lanes have reported, in any order.
- R5: resv_clr is a pulse exactly one cycle wide. On entry it comes in the cycle after the last drain completion. On exit it comes in the cycle after the redirect.
- R6: On entry, redir_vld is high for one cycle in the cycle after resv_clr, with redir_pc equal to PRIV_BASE with bit 0 set. priv_mode reads 1 from the next cycle on.
- R7: When a call is accepted, exc_addr takes the value (call PC + INSN_BYTES) with bit 0 forced to 0, visible from the next cycle. exc_addr changes at no other time.
- R8: On return, redir_vld is high for one cycle in the cycle after flush_done, with redir_pc equal to exc_addr with bit 0 cleared. priv_mode reads 0 from the next cycle on. No drain request is raised during a return.
- R9: The following requests are ignored: a call while in privileged mode, a return while in normal mode, and any call or return while a sequence is running. An ignored request leaves act_evt at 2'b00, does not start a flush and leaves exc_addr unchanged.
- R10: A flush_done or drain_done pulse that arrives while the matching request is low has no effect on later sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wb_call_vld | input | 1 | Privileged-call instruction at writeback |
| wb_call_pc | input | PC_W | Address of that call instruction |
| wb_ret_vld | input | 1 | Privileged-return instruction seen |
| flush_done | input | 1 | Pipeline flush finished |
| drain_done | input | NUM_WB | Per write-buffer drain finished |
| act_evt | output | 2 | Pipeline action: 01 entry, 10 exit, 00 none |
| hold_fetch | output | 1 | Hold fetch and issue |
| flush_req | output | 1 | Flush the whole pipeline |
| drain_req | output | NUM_WB | Drain request per write buffer |
| resv_clr | output | 1 | Clear the LL/SC reservation (pulse) |
| priv_mode | output | 1 | Current privileged-mode flag (PC bit 0) |
| exc_addr | output | PC_W | Saved exception-address register |
| redir_vld | output | 1 | PC redirect strobe |
| redir_pc | output | PC_W | PC redirect target |

## Verification
The bench builds the block with three write-buffer lanes, a 32-bit PC, 4-byte instructions and a non-zero privileged base. Three lanes allow drain completions to arrive in shuffled order, at the same time, or all in the first cycle. A full 32-bit PC allows a call placed at the top of the address space, where the saved return address wraps to zero, and a call PC with bit 0 set. Random flush and drain latencies are mixed with directed cases that inject stray done pulses and requests that must be ignored.

// File: rtl/pms_pkg.sv
package pms_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FLUSH   = 3'd1,
    ST_DRAIN   = 3'd2,
    ST_CLRRES  = 3'd3,
    ST_ENTER   = 3'd4,
    ST_RESTORE = 3'd5
  } pms_state_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_ENTRY = 2'b01,
    ACT_EXIT  = 2'b10
  } pms_act_e;

  typedef enum logic {
    DIR_ENTRY = 1'b0,
    DIR_EXIT  = 1'b1
  } pms_dir_e;

endpackage

// File: rtl/pms_rst_sync.sv
module pms_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pms_drain_track.sv
module pms_drain_track #(
  parameter int NUM_WB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic [NUM_WB-1:0] drain_done,
  output logic [NUM_WB-1:0] drain_req,
  output logic              all_done
);

  logic [NUM_WB-1:0] seen_q;
  logic [NUM_WB-1:0] seen_d;
  logic [NUM_WB-1:0] lane_ok;

  for (genvar g = 0; g < NUM_WB; g++) begin : g_lane
    assign lane_ok[g]   = seen_q[g] | drain_done[g];
    assign drain_req[g] = active & ~seen_q[g];

    always_comb begin
      if (active && !all_done) seen_d[g] = lane_ok[g];
      else                     seen_d[g] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q[g] <= 1'b0;
      else        seen_q[g] <= seen_d[g];
    end

    p_lane_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_req[g] && drain_done[g] && !all_done) |=> !drain_req[g]);
  end

  assign all_done = active & (&lane_ok);

  p_done_needs_active_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (seen_q == '0));

endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
  import pms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       call_vld,
  input  logic       ret_vld,
  input  logic       priv_mode,
  input  logic       flush_done,
  input  logic       drain_all_done,
  output logic [1:0] act_evt,
  output logic       capture,
  output logic       hold_fetch,
  output logic       flush_req,
  output logic       drain_active,
  output logic       resv_clr,
  output logic       redir_entry,
  output logic       redir_exit
);

  pms_state_e state_q, state_d;
  pms_dir_e   dir_q, dir_d;
  logic       take_call;
  logic       take_ret;
  logic       idle;

  assign idle      = (state_q == ST_IDLE);
  assign take_call = idle && call_vld && !priv_mode;
  assign take_ret  = idle && ret_vld && priv_mode;

  always_comb begin
    state_d = state_q;
    dir_d   = dir_q;
    unique case (state_q)
      ST_IDLE: begin
        if (take_call) begin
          state_d = ST_FLUSH;
          dir_d   = DIR_ENTRY;
        end else if (take_ret) begin
          state_d = ST_FLUSH;
          dir_d   = DIR_EXIT;
        end
      end
      ST_FLUSH: begin
        if (flush_done) state_d = (dir_q == DIR_ENTRY) ? ST_DRAIN : ST_RESTORE;
      end
      ST_DRAIN: begin
        if (drain_all_done) state_d = ST_CLRRES;
      end
      ST_CLRRES: begin
        state_d = (dir_q == DIR_ENTRY) ? ST_ENTER : ST_IDLE;
      end
      ST_ENTER:   state_d = ST_IDLE;
      ST_RESTORE: state_d = ST_CLRRES;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dir_q   <= DIR_ENTRY;
    end else begin
      state_q <= state_d;
      dir_q   <= dir_d;
    end
  end

  always_comb begin
    if (take_call)     act_evt = ACT_ENTRY;
    else if (take_ret) act_evt = ACT_EXIT;
    else               act_evt = ACT_NONE;
  end

  assign capture      = take_call;
  assign hold_fetch   = !idle || take_call || take_ret;
  assign flush_req    = (state_q == ST_FLUSH);
  assign drain_active = (state_q == ST_DRAIN);
  assign resv_clr     = (state_q == ST_CLRRES);
  assign redir_entry  = (state_q == ST_ENTER);
  assign redir_exit   = (state_q == ST_RESTORE);

  p_no_drain_on_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == DIR_EXIT) |-> !drain_active);

  p_drain_after_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_active) |-> $past(flush_done));

  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> (act_evt == ACT_NONE));

endmodule

// File: rtl/pms_ctx.sv
module pms_ctx #(
  parameter int               PC_W       = 32,
  parameter int               INSN_BYTES = 4,
  parameter logic [PC_W-1:0]  PRIV_BASE  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [PC_W-1:0] call_pc,
  input  logic            redir_entry,
  input  logic            redir_exit,
  output logic            priv_mode,
  output logic [PC_W-1:0] exc_addr,
  output logic            redir_vld,
  output logic [PC_W-1:0] redir_pc
);

  localparam logic [PC_W-1:0] STEP      = PC_W'(INSN_BYTES);
  localparam logic [PC_W-1:0] ENTRY_TGT = PRIV_BASE | PC_W'(1);

  logic [PC_W-1:0] exc_d;
  logic [PC_W-1:0] ret_addr;
  logic            mode_d;

  assign ret_addr = (call_pc + STEP) & ~PC_W'(1);

  always_comb begin
    exc_d = exc_addr;
    if (capture) exc_d = ret_addr;
  end

  assign redir_vld = redir_entry | redir_exit;

  always_comb begin
    if (redir_entry) redir_pc = ENTRY_TGT;
    else             redir_pc = {exc_addr[PC_W-1:1], 1'b0};
  end

  always_comb begin
    mode_d = priv_mode;
    if (redir_vld) mode_d = redir_pc[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_addr  <= '0;
      priv_mode <= 1'b0;
    end else begin
      exc_addr  <= exc_d;
      priv_mode <= mode_d;
    end
  end

  p_exc_only_on_call_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(exc_addr) |-> $past(capture));

  p_mode_set_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_entry |=> priv_mode);

  p_mode_clr_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_exit |=> !priv_mode);

  p_redir_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_entry && redir_exit));

endmodule

// File: rtl/pmode_seq_top.sv
module pmode_seq_top
  import pms_pkg::*;
#(
  parameter int               PC_W       = 32,
  parameter int               NUM_WB     = 2,
  parameter int               INSN_BYTES = 4,
  parameter logic [PC_W-1:0]  PRIV_BASE  = PC_W'(32'h0000_4000)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_call_vld,
  input  logic [PC_W-1:0]   wb_call_pc,
  input  logic              wb_ret_vld,
  input  logic              flush_done,
  input  logic [NUM_WB-1:0] drain_done,
  output logic [1:0]        act_evt,
  output logic              hold_fetch,
  output logic              flush_req,
  output logic [NUM_WB-1:0] drain_req,
  output logic              resv_clr,
  output logic              priv_mode,
  output logic [PC_W-1:0]   exc_addr,
  output logic              redir_vld,
  output logic [PC_W-1:0]   redir_pc
);

  logic rst_s_n;
  logic capture;
  logic drain_active;
  logic drain_all_done;
  logic redir_entry;
  logic redir_exit;

  pms_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  pms_fsm i_fsm (
    .clk            (clk),
    .rst_n          (rst_s_n),
    .call_vld       (wb_call_vld),
    .ret_vld        (wb_ret_vld),
    .priv_mode      (priv_mode),
    .flush_done     (flush_done),
    .drain_all_done (drain_all_done),
    .act_evt        (act_evt),
    .capture        (capture),
    .hold_fetch     (hold_fetch),
    .flush_req      (flush_req),
    .drain_active   (drain_active),
    .resv_clr       (resv_clr),
    .redir_entry    (redir_entry),
    .redir_exit     (redir_exit)
  );

  pms_drain_track #(.NUM_WB(NUM_WB)) i_drain (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .active     (drain_active),
    .drain_done (drain_done),
    .drain_req  (drain_req),
    .all_done   (drain_all_done)
  );

  pms_ctx #(
    .PC_W       (PC_W),
    .INSN_BYTES (INSN_BYTES),
    .PRIV_BASE  (PRIV_BASE)
  ) i_ctx (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .capture     (capture),
    .call_pc     (wb_call_pc),
    .redir_entry (redir_entry),
    .redir_exit  (redir_exit),
    .priv_mode   (priv_mode),
    .exc_addr    (exc_addr),
    .redir_vld   (redir_vld),
    .redir_pc    (redir_pc)
  );

  p_flush_drain_excl_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(flush_req && (|drain_req)));

  p_redirect_held_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    redir_vld |-> hold_fetch);

  p_redirect_quiet_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    redir_vld |-> (!flush_req && drain_req == '0));

  p_clear_pulse_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    resv_clr |=> !resv_clr);

  p_mode_via_redirect_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(priv_mode) |-> $past(redir_vld));

endmodule

// File: tb/test_pmode_seq_top.sv
module test_pmode_seq_top;

  localparam int          PC_W  = 32;
  localparam int          NWB   = 3;
  localparam int          STEP  = 4;
  localparam logic [31:0] PBASE = 32'h0001_2000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wb_call_vld;
  logic [PC_W-1:0] wb_call_pc;
  logic            wb_ret_vld;
  logic            flush_done;
  logic [NWB-1:0]  drain_done;
  logic [1:0]      act_evt;
  logic            hold_fetch;
  logic            flush_req;
  logic [NWB-1:0]  drain_req;
  logic            resv_clr;
  logic            priv_mode;
  logic [PC_W-1:0] exc_addr;
  logic            redir_vld;
  logic [PC_W-1:0] redir_pc;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  logic [PC_W-1:0] saved_ret;

  always #2 clk = ~clk;

  pmode_seq_top #(
    .PC_W(PC_W), .NUM_WB(NWB), .INSN_BYTES(STEP), .PRIV_BASE(PBASE)
  ) i_pmode_seq_top (
    .clk(clk), .rst_n(rst_n), .wb_call_vld(wb_call_vld), .wb_call_pc(wb_call_pc),
    .wb_ret_vld(wb_ret_vld), .flush_done(flush_done), .drain_done(drain_done),
    .act_evt(act_evt), .hold_fetch(hold_fetch), .flush_req(flush_req),
    .drain_req(drain_req), .resv_clr(resv_clr), .priv_mode(priv_mode),
    .exc_addr(exc_addr), .redir_vld(redir_vld), .redir_pc(redir_pc)
  );

  function automatic logic [PC_W-1:0] exp_ret(input logic [PC_W-1:0] pc);
    return (pc + PC_W'(STEP)) & ~PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] exp_entry();
    return PBASE | PC_W'(1);
  endfunction

  function automatic logic [NWB-1:0] exp_req(input int dl[NWB], input int c);
    logic [NWB-1:0] m;
    for (int i = 0; i < NWB; i++) m[i] = (dl[i] >= c);
    return m;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic do_entry(input logic [PC_W-1:0] pc, input int fl_dly, input int dl[NWB],
                          input bit noise);
    int maxd = 0;
    for (int i = 0; i < NWB; i++) if (dl[i] > maxd) maxd = dl[i];
    @(negedge clk);
    wb_call_vld = 1'b1; wb_call_pc = pc;
    #1;
    chk("R2 act entry", act_evt, 2'b01);
    chk("R2 hold at detect", hold_fetch, 1);
    @(negedge clk);
    wb_call_vld = 1'b0;
    saved_ret = exp_ret(pc);
    chk("R3 flush raised", flush_req, 1);
    chk("R3 no drain in flush", drain_req, 0);
    chk("R7 exc_addr saved", exc_addr, saved_ret);
    for (int k = 0; k < fl_dly; k++) begin
      if (noise && k == 0) begin
        drain_done = '1; wb_call_vld = 1'b1; wb_call_pc = ~pc;
        #1;
        chk("R9 busy call ignored", act_evt, 2'b00);
      end
      @(negedge clk);
      drain_done = '0; wb_call_vld = 1'b0;
      chk("R3 flush held", flush_req, 1);
      chk("R7 exc_addr unchanged while busy", exc_addr, saved_ret);
    end
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
    for (int c = 0; c <= maxd; c++) begin
      chk(noise && c == 0 ? "R10 all lanes still requested" : "R4 drain req", drain_req,
          exp_req(dl, c));
      chk("R3 flush dropped", flush_req, 0);
      for (int i = 0; i < NWB; i++) drain_done[i] = (dl[i] == c);
      @(negedge clk);
      drain_done = '0;
    end
    chk("R5 clear on entry", resv_clr, 1);
    chk("R4 drain idle", drain_req, 0);
    chk("R6 no early redirect", redir_vld, 0);
    @(negedge clk);
    chk("R6 redirect strobe", redir_vld, 1);
    chk("R6 redirect target", redir_pc, exp_entry());
    chk("R5 clear one cycle", resv_clr, 0);
    chk("R2 hold in redirect", hold_fetch, 1);
    @(negedge clk);
    chk("R6 redirect one cycle", redir_vld, 0);
    chk("R6 mode set", priv_mode, 1);
    chk("R2 hold released", hold_fetch, 0);
  endtask

  task automatic do_exit(input int fl_dly);
    @(negedge clk);
    wb_ret_vld = 1'b1;
    #1;
    chk("R2 act exit", act_evt, 2'b10);
    chk("R2 hold at detect", hold_fetch, 1);
    @(negedge clk);
    wb_ret_vld = 1'b0;
    chk("R3 flush raised", flush_req, 1);
    for (int k = 0; k < fl_dly; k++) begin
      @(negedge clk);
      chk("R3 flush held", flush_req, 1);
    end
    flush_done = 1'b1;
    @(negedge clk);
    flush_done = 1'b0;
    chk("R8 redirect strobe", redir_vld, 1);
    chk("R8 redirect target", redir_pc, saved_ret);
    chk("R8 no drain", drain_req, 0);
    chk("R5 no early clear", resv_clr, 0);
    @(negedge clk);
    chk("R8 mode cleared", priv_mode, 0);
    chk("R5 clear on exit", resv_clr, 1);
    chk("R2 hold in clear", hold_fetch, 1);
    @(negedge clk);
    chk("R5 clear one cycle", resv_clr, 0);
    chk("R2 hold released", hold_fetch, 0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin : stim
    int dl[NWB];
    void'($urandom(32'd5150));
    rst_n = 1'b0; wb_call_vld = 1'b0; wb_call_pc = '0; wb_ret_vld = 1'b0;
    flush_done = 1'b0; drain_done = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset flush", flush_req, 0);
    chk("R1 reset hold", hold_fetch, 0);
    chk("R1 reset mode", priv_mode, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle drain", drain_req, 0);
    chk("R1 idle redirect", redir_vld, 0);
    chk("R1 idle clear", resv_clr, 0);
    chk("R1 idle exc_addr", exc_addr, 0);

    // R9: return in normal mode ignored; R10: stray done pulses in idle
    wb_ret_vld = 1'b1; flush_done = 1'b1; drain_done = '1;
    #1;
    chk("R9 ret in normal act", act_evt, 2'b00);
    chk("R9 ret in normal hold", hold_fetch, 0);
    @(negedge clk);
    wb_ret_vld = 1'b0; flush_done = 1'b0; drain_done = '0;
    chk("R9 ret in normal no flush", flush_req, 0);
    chk("R10 stray done no drain", drain_req, 0);

    // directed: wrap at top of address space, stray drain done during flush
    dl = '{2, 0, 1};
    do_entry(32'hFFFF_FFFC, 2, dl, 1'b1);
    // R9: call while privileged ignored
    wb_call_vld = 1'b1; wb_call_pc = 32'h0000_0100;
    #1;
    chk("R9 call in priv act", act_evt, 2'b00);
    @(negedge clk);
    wb_call_vld = 1'b0;
    chk("R9 call in priv no flush", flush_req, 0);
    chk("R9 call in priv exc kept", exc_addr, 32'h0);
    do_exit(0);

    // directed: odd call PC, all lanes done at once
    dl = '{0, 0, 0};
    do_entry(32'h0000_1001, 0, dl, 1'b0);
    do_exit(3);

    for (int it = 0; it < 24; it++) begin
      for (int i = 0; i < NWB; i++) dl[i] = int'($urandom % 5);
      do_entry($urandom, int'($urandom % 4), dl, ($urandom % 3) == 0);
      repeat (int'($urandom % 3)) @(negedge clk);
      do_exit(int'($urandom % 4));
    end

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule